// File: doc/BRIEF.md
# Programmable AND-OR logic array

This block is a run-time configurable sum-of-products element. It takes `N_IN` single-bit inputs and forms `N_ROW` product terms. Each term is the AND of a chosen set of literals, and each literal is an input taken either as is or inverted. Each of the `N_OUT` outputs is the OR of the terms picked for it. One term may serve any number of outputs. The logic path from inputs to outputs has no register in it, so the outputs follow the inputs within the same cycle.

The two planes are loaded through a small write port. A plane select, an address and a data word are applied together with a write strobe, and the selected row or output mask changes at the next rising clock edge. With `FIXED_OR` set, only the product plane can be written. In that case each output is tied to its own contiguous group of `N_ROW/N_OUT` rows.

Top module: `pla_array`

## Requirements
- R1: Product row r is 1 exactly when every literal enabled in its row word holds. Bit 2i of the row word enables input i in true form. Bit 2i+1 enables input i in inverted form.
- R2: With `FIXED_OR`=0, output k is the OR of the row terms whose bit r is set in output k's mask. Bit r of the mask selects row r.
- R3: A row selected in several output masks drives all of those outputs at once.
- R4: A row whose word has no enable bit set yields 0, even when an output mask selects it.
- R5: A row that enables both the true and the inverted literal of the same input yields 0 for every input value.
- R6: With `FIXED_OR`=1, output k is the OR of rows k·G to k·G+G-1, where G = `N_ROW/N_OUT`. Writes with the output-plane select have no effect.
- R7: The outputs respond to an input change within the same clock cycle, with no clock edge in between.
- R8: A write with `cfg_we`=1 loads `cfg_data` into row `cfg_addr` (`cfg_sel_or`=0) or into output mask `cfg_addr` (`cfg_sel_or`=1). The change is visible only after the next rising edge. An address beyond the plane's size is ignored. Without a write, both planes hold their contents.
- R9: A cycle with `rst_n` low clears both planes, so every output reads 0 until the array is loaded.
- R10: Loaded as a full adder (A=in[2], B=in[1], carry-in=in[0]), with four minterm rows for the sum and three pair rows for the carry-out, the array returns the sum on out[0] and the carry-out on out[1] for all input values.
- R11: A single row with literals in[3]·!in[2]·in[1]·!in[0] detects the code 1010 and is high for no other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Synchronous active-low reset, clears both planes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel_or | input | 1 | 0 selects the product plane, 1 selects the output masks |
| cfg_addr | input | AW | Row or output index of the write |
| cfg_data | input | DW | Row word (2·N_IN bits) or output mask (N_ROW bits), low bits used |
| in_bits | input | N_IN | Logic inputs |
| out_bits | output | N_OUT | Logic outputs |

## Verification
The bench builds two instances side by side, each with 4 inputs, 8 rows and 2 outputs. One uses the programmable output plane and the other the fixed one, which gives two groups of four rows. This size holds a full adder in seven rows and a majority vote with a shared term. It also leaves spare rows for empty and contradictory terms. With three address bits against two output masks, out-of-range mask writes can be exercised. Random row and mask loads with full 16-value input sweeps are compared against a bench model of both output-plane variants.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
// pla_pkg: shared plane-select encoding and sizing helpers for the
// programmable AND-OR array. Assumes nothing beyond integer arithmetic.
package pla_pkg;

    typedef enum logic {
        PLANE_AND = 1'b0,
        PLANE_OR  = 1'b1
    } plane_e;

    // Larger of two sizes.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Address bits needed for v entries, never below one.
    function automatic int idx_bits(input int v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/pla_cfg_store.sv
`timescale 1ns/1ps
// pla_cfg_store: holds the product-plane row words and, in the programmable
// variant, the per-output row masks. Writes land on the rising edge.
// Assumes cfg_data carries the row word / mask in its low bits.
module pla_cfg_store
    import pla_pkg::*;
#(
    parameter int N_IN     = 4,
    parameter int N_ROW    = 8,
    parameter int N_OUT    = 2,
    parameter bit FIXED_OR = 1'b0,
    parameter int AW       = 3,
    parameter int DW       = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  plane_e                            cfg_plane,
    input  logic [AW-1:0]                     cfg_addr,
    input  logic [DW-1:0]                     cfg_data,
    output logic [N_ROW-1:0][2*N_IN-1:0]      and_q,
    output logic [N_OUT-1:0][N_ROW-1:0]       or_q
);

    localparam int RW = 2 * N_IN;

    genvar r;
    generate
        for (r = 0; r < N_ROW; r++) begin : g_row
            // Load one product row when addressed, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    and_q[r] <= '0;
                end else if (cfg_we && cfg_plane == PLANE_AND && cfg_addr == AW'(r)) begin
                    and_q[r] <= cfg_data[RW-1:0];
                end
            end
        end
    endgenerate

    genvar k;
    generate
        if (FIXED_OR) begin : g_fixed
            // Output plane is hard-wired downstream; no storage here.
            assign or_q = '0;
        end else begin : g_prog
            for (k = 0; k < N_OUT; k++) begin : g_out
                // Load one output mask when addressed, clear on reset.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        or_q[k] <= '0;
                    end else if (cfg_we && cfg_plane == PLANE_OR && cfg_addr == AW'(k)) begin
                        or_q[k] <= cfg_data[N_ROW-1:0];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
// pla_and_plane: forms one product term per row from the stored literal
// enables. Bit 2i enables input i true, bit 2i+1 enables it inverted.
// A row with no enables is forced to 0. Purely combinational.
module pla_and_plane #(
    parameter int N_IN  = 4,
    parameter int N_ROW = 8
) (
    input  logic [N_ROW-1:0][2*N_IN-1:0] and_q,
    input  logic [N_IN-1:0]              in_bits,
    output logic [N_ROW-1:0]             row_term
);

    genvar r;
    generate
        for (r = 0; r < N_ROW; r++) begin : g_row
            logic [N_IN-1:0] t_en;
            logic [N_IN-1:0] c_en;

            // Split the row word into true and inverted enable vectors.
            always_comb begin
                for (int i = 0; i < N_IN; i++) begin
                    t_en[i] = and_q[r][2*i];
                    c_en[i] = and_q[r][2*i+1];
                end
            end

            // AND of all enabled literals, gated off for an empty row.
            assign row_term[r] = (|and_q[r])
                               & (&(~t_en | in_bits))
                               & (&(~c_en | ~in_bits));
        end
    endgenerate

endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
// pla_or_plane: sums product terms into outputs. Programmable variant uses
// a per-output row mask; fixed variant gives output k rows k*G..k*G+G-1.
// Assumes N_ROW is a multiple of N_OUT for the fixed variant.
module pla_or_plane #(
    parameter int N_ROW    = 8,
    parameter int N_OUT    = 2,
    parameter bit FIXED_OR = 1'b0
) (
    input  logic [N_ROW-1:0]            row_term,
    input  logic [N_OUT-1:0][N_ROW-1:0] or_q,
    output logic [N_OUT-1:0]            out_bits
);

    localparam int GRP = N_ROW / N_OUT;

    genvar k;
    generate
        if (FIXED_OR) begin : g_fixed
            for (k = 0; k < N_OUT; k++) begin : g_out
                // Hard-wired group of rows per output.
                assign out_bits[k] = |row_term[k*GRP +: GRP];
            end
        end else begin : g_prog
            for (k = 0; k < N_OUT; k++) begin : g_out
                // Rows selected by this output's mask.
                assign out_bits[k] = |(row_term & or_q[k]);
            end
        end
    endgenerate

endmodule

// File: rtl/pla_array.sv
`timescale 1ns/1ps
// pla_array: top of the programmable AND-OR array. Configuration is clocked,
// the input-to-output path is combinational. FIXED_OR selects the variant
// with a hard-wired output plane.
module pla_array
    import pla_pkg::*;
#(
    parameter int N_IN     = 4,
    parameter int N_ROW    = 8,
    parameter int N_OUT    = 2,
    parameter bit FIXED_OR = 1'b0,
    localparam int AW      = max2(idx_bits(N_ROW), idx_bits(N_OUT)),
    localparam int DW      = max2(2 * N_IN, N_ROW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel_or,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_data,
    input  logic [N_IN-1:0]  in_bits,
    output logic [N_OUT-1:0] out_bits
);

    logic [N_ROW-1:0][2*N_IN-1:0] and_q;
    logic [N_OUT-1:0][N_ROW-1:0]  or_q;
    logic [N_ROW-1:0]             row_term;
    plane_e                       cfg_plane;

    // Map the plain select pin onto the plane encoding.
    assign cfg_plane = plane_e'(cfg_sel_or);

    pla_cfg_store #(
        .N_IN(N_IN), .N_ROW(N_ROW), .N_OUT(N_OUT),
        .FIXED_OR(FIXED_OR), .AW(AW), .DW(DW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_plane(cfg_plane),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .and_q(and_q), .or_q(or_q)
    );

    pla_and_plane #(.N_IN(N_IN), .N_ROW(N_ROW)) u_and (
        .and_q(and_q), .in_bits(in_bits), .row_term(row_term)
    );

    pla_or_plane #(.N_ROW(N_ROW), .N_OUT(N_OUT), .FIXED_OR(FIXED_OR)) u_or (
        .row_term(row_term), .or_q(or_q), .out_bits(out_bits)
    );

endmodule

// File: rtl/pla_array_checker.sv
`timescale 1ns/1ps
// pla_array_checker: properties over the array's planes, row terms and
// outputs. Bound into every pla_array instance.
module pla_array_checker #(
    parameter int N_IN     = 4,
    parameter int N_ROW    = 8,
    parameter int N_OUT    = 2,
    parameter bit FIXED_OR = 1'b0,
    parameter int AW       = 3,
    parameter int DW       = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_we,
    input logic                         cfg_sel_or,
    input logic [AW-1:0]                cfg_addr,
    input logic [DW-1:0]                cfg_data,
    input logic [N_OUT-1:0]             out_bits,
    input logic [N_ROW-1:0][2*N_IN-1:0] and_q,
    input logic [N_OUT-1:0][N_ROW-1:0]  or_q,
    input logic [N_ROW-1:0]             row_term
);

    localparam int GRP = N_ROW / N_OUT;

    // Planes hold their contents when no write is made.
    assert_planes_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(and_q) && $stable(or_q)));

    // First cycle after reset sees both planes cleared.
    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (and_q == '0 && or_q == '0 && out_bits == '0));

    genvar r;
    generate
        for (r = 0; r < N_ROW; r++) begin : g_row
            logic conflict;

            // Flag a row that enables both forms of some input.
            always_comb begin
                conflict = 1'b0;
                for (int i = 0; i < N_IN; i++)
                    conflict = conflict | (and_q[r][2*i] & and_q[r][2*i+1]);
            end

            assert_empty_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (and_q[r] == '0) |-> !row_term[r]);

            assert_conflict_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
                conflict |-> !row_term[r]);

            assert_row_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && !cfg_sel_or && cfg_addr == AW'(r))
                |=> (and_q[r] == $past(cfg_data[2*N_IN-1:0])));
        end
    endgenerate

    genvar k;
    generate
        for (k = 0; k < N_OUT; k++) begin : g_out
            if (FIXED_OR) begin : g_fixed
                assert_fixed_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
                    out_bits[k] == (|row_term[k*GRP +: GRP]));
            end else begin : g_prog
                assert_mask_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
                    out_bits[k] == (|(row_term & or_q[k])));
            end
        end
    endgenerate

endmodule

bind pla_array pla_array_checker #(
    .N_IN(N_IN), .N_ROW(N_ROW), .N_OUT(N_OUT),
    .FIXED_OR(FIXED_OR), .AW(AW), .DW(DW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel_or(cfg_sel_or),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .out_bits(out_bits),
    .and_q(and_q), .or_q(or_q), .row_term(row_term)
);

// File: tb/pla_array_bench.sv
`timescale 1ns/1ps
// pla_array_bench: drives a programmable and a fixed-output-plane instance
// with directed and random configurations, checking against bench models.
module pla_array_bench;

    localparam int N  = 4;
    localparam int P  = 8;
    localparam int M  = 2;
    localparam int AW = 3;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          we_p, we_f, sel_or;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [N-1:0]  in_bits;
    logic [M-1:0]  out_p, out_f;
    int            n_tests = 0;
    int            n_fail  = 0;
    bit            done    = 1'b0;

    logic [2*N-1:0] sh_and [2][P];
    logic [P-1:0]   sh_or  [M];

    always #2 clk = ~clk;

    pla_array #(.N_IN(N), .N_ROW(P), .N_OUT(M), .FIXED_OR(1'b0)) u_pla_array (
        .clk(clk), .rst_n(rst_n), .cfg_we(we_p), .cfg_sel_or(sel_or),
        .cfg_addr(addr), .cfg_data(data), .in_bits(in_bits), .out_bits(out_p)
    );

    pla_array #(.N_IN(N), .N_ROW(P), .N_OUT(M), .FIXED_OR(1'b1)) u_pla_array_fixed (
        .clk(clk), .rst_n(rst_n), .cfg_we(we_f), .cfg_sel_or(sel_or),
        .cfg_addr(addr), .cfg_data(data), .in_bits(in_bits), .out_bits(out_f)
    );

    // Enable bit for input i, inverted when neg is set (R1 encoding).
    function automatic logic [7:0] lit(input int i, input bit neg);
        return 8'(1) << (2 * i + (neg ? 1 : 0));
    endfunction

    // Reference: d=0 programmable masks, d=1 fixed groups of P/M rows.
    function automatic logic [M-1:0] model(input int d, input logic [N-1:0] x);
        logic [P-1:0] t;
        logic [M-1:0] o;
        for (int r = 0; r < P; r++) begin
            t[r] = (sh_and[d][r] != '0);
            for (int i = 0; i < N; i++) begin
                if (sh_and[d][r][2*i]   && !x[i]) t[r] = 1'b0;
                if (sh_and[d][r][2*i+1] &&  x[i]) t[r] = 1'b0;
            end
        end
        for (int k = 0; k < M; k++) begin
            o[k] = 1'b0;
            for (int r = 0; r < P; r++)
                if (t[r] && ((d == 1) ? (r / (P / M) == k) : sh_or[k][r])) o[k] = 1'b1;
        end
        return o;
    endfunction

    function automatic logic maj3(input logic [N-1:0] x);
        return (x[2] & x[1]) | (x[2] & x[0]) | (x[1] & x[0]);
    endfunction

    task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s in=%b actual=%b expected=%b", req, in_bits, act, exp);
        end
    endtask

    // One write through the configuration port of instance d.
    task automatic wr(input int d, input bit plane, input int a, input logic [DW-1:0] v);
        @(negedge clk);
        sel_or = plane;
        addr   = AW'(a);
        data   = v;
        if (d == 0) we_p = 1'b1; else we_f = 1'b1;
        @(negedge clk);
        we_p = 1'b0;
        we_f = 1'b0;
        if (!plane && a < P) sh_and[d][a] = v;
        if (plane && d == 0 && a < M) sh_or[a] = v[P-1:0];
    endtask

    task automatic clear_shadow();
        for (int r = 0; r < P; r++) begin sh_and[0][r] = '0; sh_and[1][r] = '0; end
        for (int k = 0; k < M; k++) sh_or[k] = '0;
    endtask

    task automatic clear_all();
        for (int r = 0; r < P; r++) begin wr(0, 1'b0, r, '0); wr(1, 1'b0, r, '0); end
        for (int k = 0; k < M; k++) wr(0, 1'b1, k, '0);
    endtask

    // Full input sweep of both instances against the model; sampled 1 ns
    // after the input change, well before the next rising edge (R7).
    task automatic sweep(input string req);
        for (int x = 0; x < (1 << N); x++) begin
            @(negedge clk);
            in_bits = N'(x);
            #1;
            check(req, out_p, model(0, in_bits));
            check(req, out_f, model(1, in_bits));
        end
    endtask

    task automatic load_adder(input int d);
        wr(d, 1'b0, 0, lit(2,1) | lit(1,1) | lit(0,0));
        wr(d, 1'b0, 1, lit(2,1) | lit(1,0) | lit(0,1));
        wr(d, 1'b0, 2, lit(2,0) | lit(1,1) | lit(0,1));
        wr(d, 1'b0, 3, lit(2,0) | lit(1,0) | lit(0,0));
        wr(d, 1'b0, 4, lit(2,0) | lit(1,0));
        wr(d, 1'b0, 5, lit(2,0) | lit(0,0));
        wr(d, 1'b0, 6, lit(1,0) | lit(0,0));
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; we_p = 1'b0; we_f = 1'b0; sel_or = 1'b0;
        addr = '0; data = '0; in_bits = '0;
        clear_shadow();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: cleared planes give all-zero outputs for every input.
        for (int x = 0; x < (1 << N); x++) begin
            @(negedge clk);
            in_bits = N'(x);
            #1;
            check("R9 reset", out_p, '0);
            check("R9 reset", out_f, '0);
        end

        // R10: full adder in seven rows, both output-plane variants.
        load_adder(0);
        load_adder(1);
        wr(0, 1'b1, 0, 8'h0F);
        wr(0, 1'b1, 1, 8'h70);
        wr(1, 1'b1, 0, 8'hFF);      // R6: ignored on the fixed instance
        for (int x = 0; x < (1 << N); x++) begin
            @(negedge clk);
            in_bits = N'(x);
            #1;
            check("R10 adder", out_p, {maj3(in_bits), ^in_bits[2:0]});
            check("R6 fixed adder", out_f, {maj3(in_bits), ^in_bits[2:0]});
        end

        // R8: out-of-range output-mask address has no effect.
        wr(0, 1'b1, 5, 8'hFF);
        sweep("R8 out-of-range");

        // R3: majority on out0 from rows 0..2, row 0 shared into out1.
        clear_all();
        wr(0, 1'b0, 0, lit(2,0) | lit(1,0));
        wr(0, 1'b0, 1, lit(2,0) | lit(0,0));
        wr(0, 1'b0, 2, lit(1,0) | lit(0,0));
        wr(0, 1'b1, 0, 8'h07);
        wr(0, 1'b1, 1, 8'h01);
        wr(1, 1'b0, 0, lit(2,0) | lit(1,0));
        wr(1, 1'b0, 1, lit(2,0) | lit(0,0));
        wr(1, 1'b0, 2, lit(1,0) | lit(0,0));
        for (int x = 0; x < (1 << N); x++) begin
            @(negedge clk);
            in_bits = N'(x);
            #1;
            check("R3 shared row", out_p, {in_bits[2] & in_bits[1], maj3(in_bits)});
            check("R6 fixed majority", out_f, {1'b0, maj3(in_bits)});
        end

        // R8 timing and R11: load the 1010 detector into row 3 of out1.
        wr(0, 1'b1, 1, 8'h08);
        @(negedge clk);
        in_bits = 4'b1010;
        sel_or = 1'b0; addr = 3'd3;
        data = lit(3,0) | lit(2,1) | lit(1,0) | lit(0,1);
        we_p = 1'b1;
        #1;
        check("R8 before edge", out_p, {1'b0, 1'b0});
        @(negedge clk);
        we_p = 1'b0;
        sh_and[0][3] = data;
        #1;
        check("R8 after edge", out_p, {1'b1, 1'b0});

        // R5 contradictory row 4 and R4 empty rows 5..7 added to the masks.
        wr(0, 1'b0, 4, lit(0,0) | lit(0,1) | lit(3,0));
        wr(0, 1'b1, 1, 8'h18);
        wr(0, 1'b1, 0, 8'hE7);
        for (int x = 0; x < (1 << N); x++) begin
            @(negedge clk);
            in_bits = N'(x);
            #1;
            check("R11 R5 detector", out_p[1:1], in_bits == 4'b1010);
            check("R4 empty rows", out_p[0:0], maj3(in_bits));
        end

        // R1 R2 R6: random row and mask loads swept against the model.
        for (int it = 0; it < 30; it++) begin
            for (int w = 0; w < 4; w++) begin
                wr(0, 1'b0, $urandom_range(P-1), 8'($urandom & $urandom));
                wr(1, 1'b0, $urandom_range(P-1), 8'($urandom & $urandom));
                wr(0, 1'b1, $urandom_range(M-1), 8'($urandom));
            end
            sweep("R1 R2 R6 random");
        end

        // R9: a reset in mid-run clears the loaded planes.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        clear_shadow();
        for (int x = 0; x < (1 << N); x++) begin
            @(negedge clk);
            in_bits = N'(x);
            #1;
            check("R9 mid-run reset", out_p, '0);
            check("R9 mid-run reset", out_f, '0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule